// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog counter behind a small 32-bit register bus. A down-counter steps either on every clock or only on cycles where an external 1 MHz tick enable is high. Software keeps the system alive by writing one exact key word to a restart register. That write copies a programmed reload value into the counter. If software stops writing the key, the counter steps past zero. The block then emits a one-cycle timeout event and reloads itself.

The timeout event can drive a reset request, an interrupt and an external trigger, each gated by its own control bit. A two-bit field names which reset domain the request targets. A status register keeps a record of timeouts, including whether a boot from the secondary image had been requested. Software clears the status register by writing to it. Tick generation, reset distribution and external pulse shaping are done elsewhere.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the counter and the reload register both hold RST_RELOAD (default 255). Control, status and all event outputs are zero.
- R2: Byte offset 0x00 reads the counter, 0x04 the reload value, 0x0C control bits 7:0 with zeros above, and 0x10 status. The restart register at 0x08 reads as zero. Writes to 0x00 have no effect.
- R3: A write of exactly 32'h0000_4755 to offset 0x08 loads the reload value into the counter. A write of any other value there leaves the counter untouched.
- R4: Control bit 0 enables counting. While it is clear the counter holds its value, unless a restart key is written.
- R5: Control bit 4 selects the step source. When it is 1, the counter steps only on cycles with tick_1us high. When it is 0, the counter steps on every clock.
- R6: A step taken while the counter is 0 is a timeout. In the following cycle, timeout_pulse is high for one cycle and the counter holds the reload value. Otherwise a step decrements the counter by one.
- R7: reset_req, irq and ext_trig are high together with timeout_pulse only when control bits 1, 2 and 3 respectively were set at the timeout.
- R8: reset_target reflects control bits 6:5, where 0 is SoC, 1 is full chip and 2 is CPU only. The unused code 3 is reported as 0.
- R9: Status bit 0 is set on any timeout. Status bit 1 is set on a timeout while control bit 7 is set. Any write to 0x10 clears both bits, but a timeout in the same cycle still sets its bits.
- R10: A key write in the same cycle as a step wins: the counter takes the reload value without decrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_1us | input | 1 | Step enable used when control bit 4 is set |
| timeout_pulse | output | 1 | One-cycle timeout event |
| reset_req | output | 1 | Gated reset request |
| irq | output | 1 | Gated interrupt |
| ext_trig | output | 1 | Gated external-signal trigger |
| reset_target | output | 2 | Selected reset domain |

## Verification
The hardest case to reach from the ports is a key write landing in exactly the same cycle as a counter step. A timeout or status clear coinciding with another event is similarly hard to hit. To guarantee the coincidence, the bench runs with every-clock stepping. In that mode every bus write falls on a step cycle, so right and wrong key writes both race the decrement, and the expected counter value is derived from the exact number of edges the write task spans. Timeouts are provoked with tiny reload values, so the pulse cycle and the following reload can be checked edge by edge.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [7:0] OFF_COUNT  = 8'h00;
  localparam logic [7:0] OFF_RELOAD = 8'h04;
  localparam logic [7:0] OFF_KICK   = 8'h08;
  localparam logic [7:0] OFF_CTRL   = 8'h0C;
  localparam logic [7:0] OFF_STAT   = 8'h10;
  localparam logic [31:0] KICK_KEY  = 32'h0000_4755;

  localparam int B_EN   = 0;
  localparam int B_RST  = 1;
  localparam int B_IRQ  = 2;
  localparam int B_EXT  = 3;
  localparam int B_TICK = 4;
  localparam int B_TGT  = 5;
  localparam int B_ALT  = 7;

  typedef enum logic [1:0] {
    TGT_SOC  = 2'd0,
    TGT_CHIP = 2'd1,
    TGT_CPU  = 2'd2
  } tgt_e;

  // Reserved code 3 folds onto the SoC domain.
  function automatic tgt_e map_target(input logic [1:0] field);
    return (field == 2'd3) ? TGT_SOC : tgt_e'(field);
  endfunction

  function automatic logic take_step(input logic en, input logic use_tick, input logic tick);
    return en & (use_tick ? tick : 1'b1);
  endfunction
endpackage

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_RELOAD = CNT_W'(255)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic at_zero;
  assign at_zero = (cnt_q == '0);
  assign expire  = step & at_zero & ~kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= RST_RELOAD;
    else if (kick)      cnt_q <= reload;
    else if (step)      cnt_q <= at_zero ? reload : cnt_q - 1'b1;
  end
endmodule

// File: rtl/kwd_regfile.sv
module kwd_regfile
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [CNT_W-1:0] RST_RELOAD = CNT_W'(255)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              expire,
  output logic [7:0]        ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic [1:0]        stat_q,
  output logic              kick,
  output logic [DATA_W-1:0] rdata
);
  logic hit_reload, hit_kick, hit_ctrl, hit_stat;
  assign hit_reload = (addr == ADDR_W'(OFF_RELOAD));
  assign hit_kick   = (addr == ADDR_W'(OFF_KICK));
  assign hit_ctrl   = (addr == ADDR_W'(OFF_CTRL));
  assign hit_stat   = (addr == ADDR_W'(OFF_STAT));

  assign kick = we & hit_kick & (wdata == DATA_W'(KICK_KEY));

  logic [1:0] stat_set;
  assign stat_set = {expire & ctrl_q[B_ALT], expire};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= RST_RELOAD;
      stat_q   <= '0;
    end else begin
      if (we && hit_ctrl)   ctrl_q   <= wdata[7:0];
      if (we && hit_reload) reload_q <= wdata[CNT_W-1:0];
      stat_q <= ((we && hit_stat) ? 2'b00 : stat_q) | stat_set;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_COUNT)) rdata = DATA_W'(cnt_q);
    else if (hit_reload)            rdata = DATA_W'(reload_q);
    else if (hit_ctrl)              rdata = DATA_W'(ctrl_q);
    else if (hit_stat)              rdata = DATA_W'(stat_q);
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [CNT_W-1:0] RST_RELOAD = CNT_W'(255)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_1us,
  output logic              timeout_pulse,
  output logic              reset_req,
  output logic              irq,
  output logic              ext_trig,
  output logic [1:0]        reset_target
);
  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       stat_q;
  logic             kick;
  logic             step;
  logic             expire;

  kwd_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .cnt_q(cnt_q), .expire(expire), .ctrl_q(ctrl_q), .reload_q(reload_q),
    .stat_q(stat_q), .kick(kick), .rdata(bus_rdata)
  );

  assign step = take_step(ctrl_q[B_EN], ctrl_q[B_TICK], tick_1us);

  kwd_counter #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .kick(kick), .reload(reload_q),
    .cnt_q(cnt_q), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_pulse <= 1'b0;
      reset_req     <= 1'b0;
      irq           <= 1'b0;
      ext_trig      <= 1'b0;
    end else begin
      timeout_pulse <= expire;
      reset_req     <= expire & ctrl_q[B_RST];
      irq           <= expire & ctrl_q[B_IRQ];
      ext_trig      <= expire & ctrl_q[B_EXT];
    end
  end

  assign reset_target = map_target(ctrl_q[B_TGT+1:B_TGT]);
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             kick,
  input logic             expire,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [7:0]       ctrl_q,
  input logic [1:0]       stat_q,
  input logic             timeout_pulse,
  input logic             reset_req,
  input logic             irq,
  input logic             ext_trig,
  input logic [1:0]       reset_target
);
  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !kick) |=> (cnt_q == $past(cnt_q)));

  assert_step_decrements_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !kick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_expire_reloads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (timeout_pulse && cnt_q == $past(reload_q)));

  assert_kick_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == $past(reload_q) && !timeout_pulse));

  assert_gated_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || irq || ext_trig) |-> timeout_pulse);

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (stat_q[0] && (stat_q[1] == ($past(ctrl_q[7]) | $past(stat_q[1])) || stat_q[1])));

  assert_no_reserved_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6:5] == 2'd3) |-> (reset_target == 2'd0));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .kick(kick), .expire(expire),
  .cnt_q(cnt_q), .reload_q(reload_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
  .timeout_pulse(timeout_pulse), .reset_req(reset_req), .irq(irq),
  .ext_trig(ext_trig), .reset_target(reset_target)
);

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        tick_1us = 1'b0;
  logic        timeout_pulse, reset_req, irq, ext_trig;
  logic [1:0]  reset_target;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_CNT = 5'h00, A_REL = 5'h04, A_KICK = 5'h08,
                         A_CTRL = 5'h0C, A_STAT = 5'h10;

  always #2.5 clk = ~clk;

  keyed_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .tick_1us(tick_1us),
    .timeout_pulse(timeout_pulse), .reset_req(reset_req), .irq(irq),
    .ext_trig(ext_trig), .reset_target(reset_target)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Each write spans two rising edges: one idle, one with the strobe high.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CNT, v);  check("R1 counter", v, 32'd255);
    rd(A_REL, v);  check("R1 reload", v, 32'd255);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
    rd(A_STAT, v); check("R1 status", v, 32'd0);
    check("R1 outputs", {timeout_pulse, reset_req, irq, ext_trig}, 32'd0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FF60);
    rd(A_CTRL, v); check("R2 ctrl upper bits read zero", v, 32'h60);
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd5);
    rd(A_CNT, v);  check("R2 counter write ignored", v, 32'd255);
    rd(A_KICK, v); check("R2 restart reads zero", v, 32'd0);
    wr(A_REL, 32'd1000);
    rd(A_REL, v);  check("R2 reload readback", v, 32'd1000);
  endtask

  task automatic t_key;
    logic [31:0] v;
    wr(A_KICK, 32'h0001_4755);
    rd(A_CNT, v); check("R3 wrong key ignored", v, 32'd255);
    wr(A_KICK, 32'h0000_4756);
    rd(A_CNT, v); check("R3 near key ignored", v, 32'd255);
    wr(A_KICK, 32'h0000_4755);
    rd(A_CNT, v); check("R3 key reloads", v, 32'd1000);
  endtask

  task automatic t_run_freeze;
    logic [31:0] v, c;
    wr(A_CTRL, 32'h01);
    rd(A_CNT, c); check("R4 enable write does not step", c, 32'd1000);
    repeat (7) @(negedge clk);
    rd(A_CNT, v); check("R5 clock mode steps every edge", v, c - 7);
    wr(A_KICK, 32'h0000_1234);
    rd(A_CNT, v); check("R3 wrong key while running", v, c - 9);
    wr(A_KICK, 32'h0000_4755);
    rd(A_CNT, v); check("R10 key beats step", v, 32'd1000);
    wr(A_CTRL, 32'h00);
    rd(A_CNT, c); check("R4 disable after two edges", c, 32'd998);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); check("R4 frozen while disabled", v, c);
  endtask

  task automatic t_tick;
    logic [31:0] v, c;
    wr(A_CTRL, 32'h11);
    rd(A_CNT, c);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); check("R5 no tick no step", v, c);
    for (int i = 0; i < 3; i++) begin
      tick_1us = 1'b1; @(negedge clk);
      tick_1us = 1'b0; @(negedge clk);
    end
    rd(A_CNT, v); check("R5 three ticks", v, c - 3);
    wr(A_CTRL, 32'h00);
  endtask

  task automatic t_timeout;
    logic [31:0] v;
    wr(A_REL, 32'd3);
    wr(A_KICK, 32'h0000_4755);
    wr(A_CTRL, 32'h87);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      rd(A_CNT, v); check("R6 countdown", v, 32'(3 - i));
      check("R6 no early pulse", timeout_pulse, 1'b0);
    end
    @(negedge clk);
    check("R6 pulse after zero step", timeout_pulse, 1'b1);
    check("R7 reset_req gated on", reset_req, 1'b1);
    check("R7 irq gated on", irq, 1'b1);
    check("R7 ext_trig gated off", ext_trig, 1'b0);
    rd(A_CNT, v); check("R6 reload after timeout", v, 32'd3);
    @(negedge clk);
    check("R6 pulse one cycle", timeout_pulse, 1'b0);
    rd(A_CNT, v); check("R6 keeps running", v, 32'd2);
    wr(A_CTRL, 32'h00);
    rd(A_STAT, v); check("R9 both status bits", v, 32'd3);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R9 write clears", v, 32'd0);
  endtask

  task automatic t_ext;
    logic [31:0] v;
    bit seen = 1'b0;
    wr(A_REL, 32'd1);
    wr(A_KICK, 32'h0000_4755);
    wr(A_CTRL, 32'h09);
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (timeout_pulse) begin
        seen = 1'b1;
        check("R7 ext_trig on", ext_trig, 1'b1);
        check("R7 reset_req off", reset_req, 1'b0);
        check("R7 irq off", irq, 1'b0);
      end
    end
    check("R6 timeout seen", seen, 1'b1);
    wr(A_CTRL, 32'h00);
    rd(A_STAT, v); check("R9 bit1 needs alt boot", v, 32'd1);
    wr(A_STAT, 32'hFFFF);
  endtask

  task automatic t_target;
    wr(A_CTRL, 32'h20); check("R8 full chip", reset_target, 2'd1);
    wr(A_CTRL, 32'h40); check("R8 cpu", reset_target, 2'd2);
    wr(A_CTRL, 32'h60); check("R8 reserved to soc", reset_target, 2'd0);
    wr(A_CTRL, 32'h00); check("R8 soc", reset_target, 2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_key();
    t_run_freeze();
    t_tick();
    t_timeout();
    t_ext();
    t_target();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule